// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device

This block is the device end of a three-wire serial memory link. A host raises chip select, clocks commands in on a serial clock with data on a serial input line, and receives replies on a serial output that is released (high impedance) whenever the device has nothing to say. The storage is a 256-word by 16-bit array held in registers.

The host can read a word, and can keep the clock running to stream the following words. It can write a word once the write-enable latch has been set. It can also set or clear that latch. A write is taken in fully while chip select is high and is committed only when chip select drops. A self-timed programming interval follows, counted in system clock cycles. During that interval, raising chip select makes the output report busy, and afterwards it reports ready.

The serial pins are sampled by the system clock through a synchronizer. The serial clock must therefore run well below the system clock.

Top module: `mw_eeprom`

## Requirements
- R1: After chip select rises, any number of 0 bits on `di` are ignored; the first 1 sampled on a rising serial clock edge is the start bit, and the command is decoded from the following bit.
- R2: A read is the start bit, the opcode 10 and an 8-bit address sent MSB first; on the serial clock rise that captures the last address bit, `do_oe` goes to 1 with `do_out` = 0 (a dummy zero).
- R3: The 16 data bits of the addressed word follow on `do_out`, bit 15 first, one bit per subsequent serial clock rise.
- R4: If the serial clock keeps running with chip select high after bit 0 of a word, the next rise presents bit 15 of the word at address+1 (255 wraps to 0), with no dummy bit and no new command.
- R5: The write-enable latch is clear after reset. Opcode 00 followed by address bits 7:6 = 11 sets it. Opcode 00 followed by address bits 7:6 = 00 clears it. It keeps its value across chip select cycles.
- R6: Reads return stored data whether the write-enable latch is set or clear.
- R7: A write is the start bit, the opcode 01, an 8-bit address MSB first and 16 data bits MSB first, which is 27 serial clocks in all. Nothing is stored, and no status is driven, until chip select falls after the 27th clock. The word is then stored.
- R8: A write whose chip select falls before its 27th serial clock leaves the array unchanged and starts no busy period.
- R9: A write received while the write-enable latch is clear leaves the array unchanged and starts no busy period (`do_oe` stays 0 when chip select is next raised).
- R10: For WRITE_CYCLES system clocks after a write is committed, chip select high gives `do_oe` = 1 with `do_out` = 0, and no command clocked in meanwhile is accepted.
- R11: After the programming interval ends with chip select high, `do_out` = 1 with `do_oe` = 1. Once chip select falls, `do_oe` returns to 0.
- R12: `do_oe` is 0 at reset and whenever no read data or write status is being presented, including while a command is being clocked in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins and times writes |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| do_out | output | 1 | Serial data / status value to the host |
| do_oe | output | 1 | Output enable for `do_out`; 0 means high impedance |

## Verification
The bench keeps the default address and word widths and the default two synchronizer stages. It overrides WRITE_CYCLES to 400, which makes the programming interval long enough for a complete read command to be clocked in while the device is busy. That shows the command is refused and that the status flips from busy to ready with chip select held high. The interval is still short enough that several writes, wrap-around streaming reads and the truncated and unprivileged writes fit in a brief run.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [1:0] {
    OP_CTRL  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_SPARE = 2'b11
  } mw_op_e;

  typedef enum logic [1:0] {
    CT_NONE,
    CT_ENABLE,
    CT_DISABLE
  } mw_ctl_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HUNT,
    S_OP,
    S_ADDR,
    S_DATA,
    S_ARMED,
    S_READ,
    S_HOLD
  } mw_state_e;

  // Control sub-command from the two top address bits.
  function automatic mw_ctl_e mw_ctl_decode(input logic [1:0] top2);
    case (top2)
      2'b11:   return CT_ENABLE;
      2'b00:   return CT_DISABLE;
      default: return CT_NONE;
    endcase
  endfunction

  // Streaming read address step, wraps at the top of the array.
  function automatic logic [7:0] mw_step8(input logic [7:0] a);
    return a + 8'd1;
  endfunction

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic cs_s,
  output logic di_s,
  output logic sk_rise
);

  logic [STAGES-1:0] cs_p;
  logic [STAGES-1:0] di_p;
  logic [STAGES:0]   sk_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= '0;
      di_p <= '0;
      sk_p <= '0;
    end else begin
      cs_p[0] <= cs;
      di_p[0] <= di;
      sk_p[0] <= sk;
      for (int i = 1; i < STAGES; i++) begin
        cs_p[i] <= cs_p[i-1];
        di_p[i] <= di_p[i-1];
      end
      for (int i = 1; i <= STAGES; i++) begin
        sk_p[i] <= sk_p[i-1];
      end
    end
  end

  assign cs_s    = cs_p[STAGES-1];
  assign di_s    = di_p[STAGES-1];
  assign sk_rise = sk_p[STAGES-1] & ~sk_p[STAGES];

endmodule

// File: rtl/mw_cmd.sv
module mw_cmd
  import mw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sk_rise,
  input  logic              di_s,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wen,
  output logic              rd_active,
  output logic              do_bit,
  output logic              cmd_active,
  output logic              rd_start,
  output logic              start_evt,
  output logic              ctl_evt
);

  localparam int CNT_MAX = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNT_W   = $clog2(CNT_MAX) + 1;

  mw_state_e         state;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wen_q;
  logic              do_bit_q;

  logic [ADDR_W-1:0] addr_in;
  logic [ADDR_W-1:0] addr_nx;
  logic              addr_last;
  logic              data_last;
  mw_op_e            op_cur;
  mw_ctl_e           ctl_cur;

  assign addr_in   = {addr_q[ADDR_W-2:0], di_s};
  assign addr_nx   = addr_q + ADDR_W'(1);
  assign addr_last = (cnt_q == CNT_W'(ADDR_W-1));
  assign data_last = (cnt_q == CNT_W'(DATA_W-1));
  assign op_cur    = mw_op_e'(op_q);
  assign ctl_cur   = mw_ctl_decode(addr_in[ADDR_W-1 -: 2]);

  assign rd_addr   = (state == S_READ) ? addr_nx : addr_in;

  assign start_evt = (state == S_HUNT) && sk_rise && di_s;
  assign rd_start  = (state == S_ADDR) && sk_rise && addr_last && (op_cur == OP_READ);
  assign ctl_evt   = (state == S_ADDR) && sk_rise && addr_last && (op_cur == OP_CTRL)
                     && (ctl_cur != CT_NONE);
  assign commit    = (state == S_ARMED) && !cs_s;

  assign wr_addr    = addr_q;
  assign wr_data    = data_q;
  assign wen        = wen_q;
  assign rd_active  = (state == S_READ);
  assign do_bit     = do_bit_q;
  assign cmd_active = (state != S_IDLE) && (state != S_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      shift_q  <= '0;
      cnt_q    <= '0;
      wen_q    <= 1'b0;
      do_bit_q <= 1'b0;
    end else if (!cs_s) begin
      state <= S_IDLE;
      cnt_q <= '0;
    end else begin
      case (state)
        S_IDLE: state <= busy ? S_HOLD : S_HUNT;
        S_HUNT: begin
          if (start_evt) begin
            state <= S_OP;
            cnt_q <= '0;
          end
        end
        S_OP: begin
          if (sk_rise) begin
            op_q <= {op_q[0], di_s};
            if (cnt_q == CNT_W'(1)) begin
              state <= S_ADDR;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        S_ADDR: begin
          if (sk_rise) begin
            addr_q <= addr_in;
            if (addr_last) begin
              cnt_q <= '0;
              case (op_cur)
                OP_READ: begin
                  state    <= S_READ;
                  shift_q  <= rd_data;
                  do_bit_q <= 1'b0;
                end
                OP_WRITE: state <= S_DATA;
                OP_CTRL: begin
                  state <= S_HOLD;
                  if (ctl_cur == CT_ENABLE)  wen_q <= 1'b1;
                  if (ctl_cur == CT_DISABLE) wen_q <= 1'b0;
                end
                default: state <= S_HOLD;
              endcase
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        S_DATA: begin
          if (sk_rise) begin
            data_q <= {data_q[DATA_W-2:0], di_s};
            if (data_last) state <= S_ARMED;
            else           cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        S_READ: begin
          if (sk_rise) begin
            do_bit_q <= shift_q[DATA_W-1];
            if (data_last) begin
              cnt_q   <= '0;
              addr_q  <= addr_nx;
              shift_q <= rd_data;
            end else begin
              cnt_q   <= cnt_q + CNT_W'(1);
              shift_q <= {shift_q[DATA_W-2:0], 1'b0};
            end
          end
        end
        default: state <= state;
      endcase
    end
  end

endmodule

// File: rtl/mw_store.sv
module mw_store #(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 16,
  parameter int WRITE_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              wen,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              cs_s,
  input  logic              start_evt,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              stat_q
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int TW    = $clog2(WRITE_CYCLES + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [TW-1:0]     timer_q;
  logic              accept;

  assign accept  = commit && wen;
  assign busy    = (timer_q != '0);
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (accept) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
      stat_q  <= 1'b0;
    end else begin
      if (accept)       timer_q <= TW'(WRITE_CYCLES);
      else if (busy)    timer_q <= timer_q - TW'(1);
      if (accept)                          stat_q <= 1'b1;
      else if (start_evt || (!cs_s && !busy)) stat_q <= 1'b0;
    end
  end

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 16,
  parameter int WRITE_CYCLES = 5000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_out,
  output logic do_oe
);

  logic              cs_s, di_s, sk_rise;
  logic              busy, stat_q, wen, commit;
  logic              rd_active, do_bit, cmd_active, rd_start, start_evt, ctl_evt;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;

  mw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise)
  );

  mw_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sk_rise(sk_rise), .di_s(di_s),
    .busy(busy), .rd_data(rd_data), .rd_addr(rd_addr), .commit(commit),
    .wr_addr(wr_addr), .wr_data(wr_data), .wen(wen), .rd_active(rd_active),
    .do_bit(do_bit), .cmd_active(cmd_active), .rd_start(rd_start),
    .start_evt(start_evt), .ctl_evt(ctl_evt)
  );

  mw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_CYCLES(WRITE_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit), .wen(wen), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .cs_s(cs_s), .start_evt(start_evt),
    .rd_data(rd_data), .busy(busy), .stat_q(stat_q)
  );

  // Read data has priority; otherwise the line carries write status.
  assign do_oe  = cs_s && (rd_active || stat_q);
  assign do_out = do_oe && (rd_active ? do_bit : !busy);

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
  parameter int WRITE_CYCLES = 5000
) (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic busy,
  input logic wen,
  input logic rd_start,
  input logic cmd_active,
  input logic rd_active,
  input logic stat_q,
  input logic ctl_evt,
  input logic do_oe,
  input logic do_out
);

  logic [31:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 32'd1;
    else           busy_run <= '0;
  end

  p_dummy_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start && cs_s |=> !cs_s || (do_oe && !do_out));

  p_no_cmd_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_active);

  p_busy_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= WRITE_CYCLES);

  p_busy_needs_wen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen));

  p_wen_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_evt |=> $stable(wen));

  p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_active && !stat_q) |-> !do_oe);

  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && stat_q && !busy && !rd_active) |-> (do_oe && do_out));

endmodule

bind mw_eeprom mw_eeprom_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .busy(busy), .wen(wen),
  .rd_start(rd_start), .cmd_active(cmd_active), .rd_active(rd_active),
  .stat_q(stat_q), .ctl_evt(ctl_evt), .do_oe(do_oe), .do_out(do_out)
);

// File: tb/sim_mw_eeprom.sv
`timescale 1ns/1ps
module sim_mw_eeprom;

  localparam int WC = 400;

  logic clk = 1'b0;
  logic rst_n, cs, sk, di;
  logic do_out, do_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit mon_on = 0;
  bit model_wen = 0;
  logic [15:0] model [256];
  logic  exp_q [$];
  string tag_q [$];

  always #10 clk = ~clk;

  mw_eeprom #(.WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .do_out(do_out), .do_oe(do_oe)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    di = b;
    wait_clk(3);
    sk = 1'b1;
    wait_clk(6);
    sk = 1'b0;
    wait_clk(3);
  endtask

  task automatic head(input logic [1:0] op, input logic [7:0] a, input int lead0,
                      input bit last_addr);
    cs = 1'b1;
    wait_clk(4);
    repeat (lead0) pulse(1'b0);
    pulse(1'b1);
    pulse(op[1]);
    pulse(op[0]);
    for (int i = 7; i >= 1; i--) pulse(a[i]);
    if (last_addr) pulse(a[0]);
  endtask

  // Driver: queues the expected serial bits, then clocks the read.
  task automatic do_read(input logic [7:0] a, input int nw, input int lead0,
                         input string tag);
    logic [7:0] p;
    p = a;
    exp_q.push_back(1'b0);
    tag_q.push_back({tag, " dummy"});
    for (int w = 0; w < nw; w++) begin
      for (int b = 15; b >= 0; b--) begin
        exp_q.push_back(model[p][b]);
        tag_q.push_back(tag);
      end
      p = p + 8'd1;
    end
    head(2'b10, a, lead0, 1'b0);
    mon_on = 1;
    pulse(a[0]);
    repeat (16 * nw) pulse(1'b0);
    mon_on = 0;
    cs = 1'b0;
    wait_clk(6);
    chk(exp_q.size() == 0, {tag, " all bits seen"}, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d, input int nb);
    head(2'b01, a, 0, 1'b1);
    for (int i = 15; i > 15 - nb; i--) pulse(d[i]);
    chk(do_oe == 1'b0, "R7 no status before cs falls", do_oe, 0);
    cs = 1'b0;
    wait_clk(4);
    if (nb == 16 && model_wen) model[a] = d;
  endtask

  task automatic do_ctl(input bit en);
    head(2'b00, en ? 8'hC0 : 8'h00, 1, 1'b1);
    cs = 1'b0;
    wait_clk(4);
    model_wen = en;
  endtask

  // Monitor: compares each queued bit after its serial clock rise.
  always @(negedge sk) begin
    if (mon_on && exp_q.size() > 0) begin
      logic e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(do_oe === 1'b1 && do_out === e, t, {do_oe, do_out}, {1'b1, e});
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
    rst_n = 1'b0; cs = 1'b0; sk = 1'b0; di = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    chk(do_oe == 1'b0, "R12 reset", do_oe, 0);
    cs = 1'b1;
    wait_clk(6);
    pulse(1'b0);
    chk(do_oe == 1'b0, "R12 idle with cs high", do_oe, 0);
    cs = 1'b0;
    wait_clk(4);

    do_read(8'h05, 1, 3, "R1 R2 R3 R6");

    do_write(8'h10, 16'hA5C3, 16);
    cs = 1'b1; wait_clk(6);
    chk(do_oe == 1'b0, "R9 no busy without enable", do_oe, 0);
    cs = 1'b0; wait_clk(4);
    do_read(8'h10, 1, 0, "R9 array unchanged");

    do_ctl(1'b1);
    do_write(8'h10, 16'hA5C3, 16);
    cs = 1'b1; wait_clk(4);
    chk(do_oe == 1'b1 && do_out == 1'b0, "R10 busy", {do_oe, do_out}, 2'b10);
    pulse(1'b1); pulse(1'b1); pulse(1'b0);
    for (int i = 7; i >= 0; i--) pulse(1'b0);
    pulse(1'b0);
    chk(do_oe == 1'b1 && do_out == 1'b0, "R10 command refused while busy",
        {do_oe, do_out}, 2'b10);
    wait_clk(WC);
    chk(do_oe == 1'b1 && do_out == 1'b1, "R11 ready", {do_oe, do_out}, 2'b11);
    pulse(1'b0);
    chk(do_oe == 1'b1 && do_out == 1'b1, "R10 no command after busy ends",
        {do_oe, do_out}, 2'b11);
    cs = 1'b0; wait_clk(4);
    chk(do_oe == 1'b0, "R11 release on cs low", do_oe, 0);

    do_write(8'h11, 16'h1234, 16); wait_clk(WC + 20);
    do_write(8'hFF, 16'hBEEF, 16); wait_clk(WC + 20);
    do_write(8'h00, 16'h0F0F, 16); wait_clk(WC + 20);
    do_read(8'h10, 2, 0, "R7 R3 R4");
    do_read(8'hFF, 2, 2, "R4 wrap");

    do_write(8'h20, 16'h5555, 10);
    cs = 1'b1; wait_clk(6);
    chk(do_oe == 1'b0, "R8 no busy after short write", do_oe, 0);
    cs = 1'b0; wait_clk(4);
    do_read(8'h20, 1, 0, "R8 array unchanged");

    do_ctl(1'b0);
    do_write(8'h30, 16'h1111, 16);
    cs = 1'b1; wait_clk(6);
    chk(do_oe == 1'b0, "R5 R9 latch cleared", do_oe, 0);
    cs = 1'b0; wait_clk(4);
    do_read(8'h30, 1, 0, "R5 R9 R6");
    do_read(8'h11, 1, 0, "R6 read with latch clear");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_clk(150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule